// File: doc/BRIEF.md
# Presettable Synchronous Up/Down Counter

This block is a four-bit counter that counts up or down and can be preset. Every change of state happens on the rising clock edge. A parameter chosen at elaboration sets the count sequence. It is either a decimal decade, 0 to 9, or a full sixteen-state binary cycle.

A preset input that is active low has priority over counting. When it is low, the four data inputs are captured. Counting happens only when both active-low enables are low. These are the parallel enable and the trickle enable.

The active-low terminal-count output is decoded from the registered state, the direction input and the trickle enable. It does not depend on the parallel enable. Wider counters are built by chaining stages on one clock. Each stage's terminal count drives the trickle enable of the next stage.

In decade mode the six states above 9 can be entered by a preset or by reset-free start-up. The counter leaves them and returns to 0 to 9 within two counts.

Top module: `updn_counter`

## Requirements
- R1: While `rst_n` is low the state `q` is 0. The state is still 0 on the first clock edge after `rst_n` rises if no load or count is requested.
- R2: When `load_n` is 0 at a rising edge, `q` takes the value of `din`, whatever the values of `en_par_n`, `en_trk_n` and `up`.
- R3: With `load_n` at 1, `q` holds its value across an edge if `en_par_n` or `en_trk_n` is 1.
- R4: When counting (`load_n`=1, both enables 0) with `up`=1, a decade counter in states 0 to 8 steps to q+1, and state 9 wraps to 0.
- R5: When counting with `up`=0, a decade counter steps from q to q-1 for states 1 to 9, and state 0 wraps to 9.
- R6: `tc_n` is 1 whenever `en_trk_n` is 1. With `en_trk_n`=0 it is 0 at state 9 with `up`=1 and at state 0 with `up`=0; in the legal decade range it is 1 otherwise.
- R7: `tc_n` does not depend on `en_par_n`. With `en_par_n`=1 and the other conditions of R6 met, it is still 0.
- R8: In decade mode with `up`=1 and `en_trk_n`=0, `tc_n` is also 0 in states 11, 13 and 15. It is 1 in states 10, 12 and 14.
- R9: In decade mode, counting up from an illegal state gives 10→11, 11→6, 12→13, 13→4, 14→15 and 15→2.
- R10: In decade mode, counting down from a state n in 10 to 15 gives n-1, with bit 3 cleared when n-1 is above 9. So 10→9, 11→2, 12→3, 13→4, 14→5 and 15→6.
- R11: In decade mode, from any state 10 to 15, at most two counts in a fixed direction bring `q` into 0 to 9.
- R12: With `DECADE`=0 the counter cycles through all 16 values. It wraps 15→0 going up and 0→15 going down, and `tc_n` is 0 at 15 going up and at 0 going down when `en_trk_n`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to state 0 |
| load_n | input | 1 | Active-low preset; captures `din` |
| din | input | 4 | Preset value |
| en_par_n | input | 1 | Active-low parallel count enable |
| en_trk_n | input | 1 | Active-low trickle count enable; also gates `tc_n` |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| q | output | 4 | Counter state |
| tc_n | output | 1 | Active-low terminal count |

## Verification
Preset and count can be requested in the same cycle. The bench drives `load_n` low while both enables are low, with `up` both high and low. It then checks that `q` equals `din` and not the neighbouring count value, and that `tc_n` is decoded from the loaded value. Hold and terminal count also meet in one cycle. A raised `en_par_n` must freeze `q` while `tc_n` still shows the terminal state, and this is judged at the ports one edge later.

// File: rtl/updn_pkg.sv
package updn_pkg;
  localparam int CW = 4;
  typedef logic [CW-1:0] cnt_t;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_UP   = 2'd2,
    OP_DOWN = 2'd3
  } op_e;
endpackage

// File: rtl/updn_opsel.sv
module updn_opsel
  import updn_pkg::*;
(
  input  logic load_n,
  input  logic en_par_n,
  input  logic en_trk_n,
  input  logic up,
  output op_e  op
);
  always_comb begin
    if (!load_n)                    op = OP_LOAD;
    else if (en_par_n || en_trk_n)  op = OP_HOLD;
    else if (up)                    op = OP_UP;
    else                            op = OP_DOWN;
  end
endmodule

// File: rtl/updn_next.sv
module updn_next
  import updn_pkg::*;
#(
  parameter bit DECADE = 1'b1
) (
  input  cnt_t q,
  input  cnt_t din,
  input  op_e  op,
  output cnt_t nxt
);
  localparam cnt_t TOP = DECADE ? cnt_t'(9) : cnt_t'((1 << CW) - 1);

  cnt_t inc_v;
  cnt_t dec_v;

  generate
    if (DECADE) begin : g_dec
      // decade increment: legal wrap at 9, illegal states fold back in <=2 steps
      always_comb begin
        unique case (q)
          4'd9:    inc_v = 4'd0;
          4'd10:   inc_v = 4'd11;
          4'd11:   inc_v = 4'd6;
          4'd12:   inc_v = 4'd13;
          4'd13:   inc_v = 4'd4;
          4'd14:   inc_v = 4'd15;
          4'd15:   inc_v = 4'd2;
          default: inc_v = q + 4'd1;
        endcase
      end
      // decade decrement: wrap 0->9, clear bit 3 when result still illegal
      always_comb begin
        if (q == '0) begin
          dec_v = TOP;
        end else begin
          dec_v = q - 4'd1;
          if (dec_v > TOP) dec_v[3] = 1'b0;
        end
      end
    end else begin : g_bin
      always_comb begin
        inc_v = q + cnt_t'(1);
        dec_v = q - cnt_t'(1);
      end
    end
  endgenerate

  always_comb begin
    unique case (op)
      OP_LOAD: nxt = din;
      OP_UP:   nxt = inc_v;
      OP_DOWN: nxt = dec_v;
      default: nxt = q;
    endcase
  end
endmodule

// File: rtl/updn_tc.sv
module updn_tc
  import updn_pkg::*;
#(
  parameter bit DECADE = 1'b1
) (
  input  cnt_t q,
  input  logic up,
  input  logic en_trk_n,
  output logic tc_n
);
  logic at_top;
  logic at_zero;

  generate
    if (DECADE) begin : g_dec
      // partial decode of 9: bits 0 and 3 only, so 11/13/15 also match
      assign at_top = q[0] & q[3];
    end else begin : g_bin
      assign at_top = &q;
    end
  endgenerate

  assign at_zero = ~|q;
  assign tc_n = ~(~en_trk_n & (up ? at_top : at_zero));
endmodule

// File: rtl/updn_counter.sv
module updn_counter
  import updn_pkg::*;
#(
  parameter bit DECADE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_n,
  input  logic [CW-1:0] din,
  input  logic          en_par_n,
  input  logic          en_trk_n,
  input  logic          up,
  output logic [CW-1:0] q,
  output logic          tc_n
);
  op_e  op;
  cnt_t nxt;
  cnt_t q_r;

  updn_opsel u_opsel (
    .load_n   (load_n),
    .en_par_n (en_par_n),
    .en_trk_n (en_trk_n),
    .up       (up),
    .op       (op)
  );

  updn_next #(.DECADE(DECADE)) u_next (
    .q   (q_r),
    .din (din),
    .op  (op),
    .nxt (nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= nxt;
  end

  updn_tc #(.DECADE(DECADE)) u_tc (
    .q        (q_r),
    .up       (up),
    .en_trk_n (en_trk_n),
    .tc_n     (tc_n)
  );

  assign q = q_r;
endmodule

// File: rtl/updn_counter_chk.sv
module updn_counter_chk
  import updn_pkg::*;
#(
  parameter bit DECADE = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_n,
  input logic [CW-1:0] din,
  input logic          en_par_n,
  input logic          en_trk_n,
  input logic          up,
  input logic [CW-1:0] q,
  input logic          tc_n
);
  logic counting;
  assign counting = load_n && !en_par_n && !en_trk_n;

  a_r2_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> q == $past(din));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && (en_par_n || en_trk_n)) |=> $stable(q));

  a_r6_tc_gated: assert property (@(posedge clk) disable iff (!rst_n)
    en_trk_n |-> tc_n);

  a_r4_legal_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (DECADE && load_n && q <= 4'd9) |=> q <= 4'd9);

  a_r10_down_recovers: assert property (@(posedge clk) disable iff (!rst_n)
    (DECADE && counting && !up && q > 4'd9) |=> q <= 4'd9);

  a_r9_odd_up_recovers: assert property (@(posedge clk) disable iff (!rst_n)
    (DECADE && counting && up && q > 4'd9 && q[0]) |=> q <= 4'd9);
endmodule

bind updn_counter updn_counter_chk #(.DECADE(DECADE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .load_n   (load_n),
  .din      (din),
  .en_par_n (en_par_n),
  .en_trk_n (en_trk_n),
  .up       (up),
  .q        (q),
  .tc_n     (tc_n)
);

// File: tb/updn_counter_tb.sv
module updn_counter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_n = 1'b1;
  logic [3:0] din = 4'd0;
  logic       en_par_n = 1'b1;
  logic       en_trk_n = 1'b1;
  logic       up = 1'b1;
  logic [3:0] q, qb;
  logic       tc_n, tcb_n;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  updn_counter #(.DECADE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
    .en_par_n(en_par_n), .en_trk_n(en_trk_n), .up(up),
    .q(q), .tc_n(tc_n)
  );

  updn_counter #(.DECADE(1'b0)) u_bin (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
    .en_par_n(en_par_n), .en_trk_n(en_trk_n), .up(up),
    .q(qb), .tc_n(tcb_n)
  );

  // {load_n, en_par_n, en_trk_n, up, din[3:0], exp_q[3:0], exp_tc_n}
  localparam int NV = 34;
  localparam logic [12:0] VEC [NV] = '{
    {1'b0,1'b1,1'b1,1'b1,4'd7, 4'd7, 1'b1},  // R2 load, enables off
    {1'b1,1'b0,1'b0,1'b1,4'd0, 4'd8, 1'b1},  // R4 up
    {1'b1,1'b0,1'b0,1'b1,4'd0, 4'd9, 1'b0},  // R4 R6 at 9 up
    {1'b1,1'b0,1'b0,1'b1,4'd0, 4'd0, 1'b1},  // R4 wrap
    {1'b1,1'b0,1'b0,1'b0,4'd0, 4'd9, 1'b1},  // R5 wrap 0->9
    {1'b1,1'b0,1'b0,1'b0,4'd0, 4'd8, 1'b1},  // R5 down
    {1'b1,1'b0,1'b0,1'b1,4'd0, 4'd9, 1'b0},  // R4 up again
    {1'b1,1'b1,1'b0,1'b1,4'd0, 4'd9, 1'b0},  // R3 R7 hold, tc with par high
    {1'b1,1'b0,1'b1,1'b1,4'd0, 4'd9, 1'b1},  // R3 R6 hold, trk high
    {1'b0,1'b0,1'b0,1'b0,4'd0, 4'd0, 1'b0},  // R2 R6 load over count, zero down
    {1'b1,1'b0,1'b0,1'b0,4'd0, 4'd9, 1'b1},  // R5
    {1'b0,1'b0,1'b0,1'b1,4'd12,4'd12,1'b1},  // R2 R8 load 12
    {1'b1,1'b0,1'b0,1'b1,4'd0, 4'd13,1'b0},  // R9 R8
    {1'b1,1'b0,1'b0,1'b1,4'd0, 4'd4, 1'b1},  // R9 13->4
    {1'b0,1'b0,1'b0,1'b1,4'd15,4'd15,1'b0},  // R8 load 15
    {1'b1,1'b0,1'b0,1'b1,4'd0, 4'd2, 1'b1},  // R9 15->2
    {1'b0,1'b0,1'b0,1'b1,4'd10,4'd10,1'b1},  // R8 load 10
    {1'b1,1'b0,1'b0,1'b1,4'd0, 4'd11,1'b0},  // R9 R8
    {1'b1,1'b0,1'b0,1'b1,4'd0, 4'd6, 1'b1},  // R9 11->6
    {1'b0,1'b0,1'b0,1'b1,4'd14,4'd14,1'b1},  // R8 load 14
    {1'b1,1'b0,1'b0,1'b1,4'd0, 4'd15,1'b0},  // R9 14->15
    {1'b1,1'b0,1'b0,1'b1,4'd0, 4'd2, 1'b1},  // R9
    {1'b0,1'b0,1'b0,1'b0,4'd13,4'd13,1'b1},  // R2 load 13 down
    {1'b1,1'b0,1'b0,1'b0,4'd0, 4'd4, 1'b1},  // R10 13->4
    {1'b0,1'b0,1'b0,1'b0,4'd10,4'd10,1'b1},  // load 10
    {1'b1,1'b0,1'b0,1'b0,4'd0, 4'd9, 1'b1},  // R10 10->9
    {1'b0,1'b0,1'b0,1'b0,4'd15,4'd15,1'b1},  // load 15
    {1'b1,1'b0,1'b0,1'b0,4'd0, 4'd6, 1'b1},  // R10 15->6
    {1'b0,1'b0,1'b0,1'b0,4'd11,4'd11,1'b1},  // load 11
    {1'b1,1'b0,1'b0,1'b0,4'd0, 4'd2, 1'b1},  // R10 11->2
    {1'b0,1'b0,1'b0,1'b0,4'd12,4'd12,1'b1},  // load 12
    {1'b1,1'b0,1'b0,1'b0,4'd0, 4'd3, 1'b1},  // R10 12->3
    {1'b0,1'b0,1'b0,1'b0,4'd14,4'd14,1'b1},  // load 14
    {1'b1,1'b0,1'b0,1'b0,4'd0, 4'd5, 1'b1}   // R10 14->5
  };

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual q=%0d tc_n=%0b expected q=%0d tc_n=%0b",
               req, act[4:1], act[0], exp[4:1], exp[0]);
    end
  endtask

  task automatic step(input logic l, input logic p, input logic t, input logic u, input logic [3:0] d);
    @(negedge clk);
    load_n = l; en_par_n = p; en_trk_n = t; up = u; din = d;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #3;
    check("R1 in reset", {q, tc_n}, {4'd0, 1'b1});
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    check("R1 after release", {q, tc_n}, {4'd0, 1'b1});

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8:5]);
      check($sformatf("vector %0d", i), {q, tc_n}, VEC[i][4:0]);
    end

    // R8: tc_n high in even illegal states going up
    step(1'b0, 1'b1, 1'b0, 1'b1, 4'd12);
    check("R8 state 12 up", {q, tc_n}, {4'd12, 1'b1});

    // R11: every illegal state, both directions, legal within two counts
    for (int s = 10; s < 16; s++) begin
      for (int dir = 0; dir < 2; dir++) begin
        step(1'b0, 1'b1, 1'b1, dir[0], 4'(s));
        step(1'b1, 1'b0, 1'b0, dir[0], 4'd0);
        step(1'b1, 1'b0, 1'b0, dir[0], 4'd0);
        checks++;
        if (q > 4'd9) begin
          failures++;
          $display("FAIL R11 from %0d dir %0d actual q=%0d expected <=9", s, dir, q);
        end
      end
    end

    // R12: binary variant
    step(1'b0, 1'b1, 1'b1, 1'b1, 4'd14);
    check("R12 load 14", {qb, tcb_n}, {4'd14, 1'b1});
    step(1'b1, 1'b0, 1'b0, 1'b1, 4'd0);
    check("R12 up to 15 tc", {qb, tcb_n}, {4'd15, 1'b0});
    step(1'b1, 1'b0, 1'b0, 1'b1, 4'd0);
    check("R12 wrap 15->0", {qb, tcb_n}, {4'd0, 1'b1});
    step(1'b1, 1'b1, 1'b0, 1'b0, 4'd0);
    check("R12 zero down tc", {qb, tcb_n}, {4'd0, 1'b0});
    step(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
    check("R12 wrap 0->15", {qb, tcb_n}, {4'd15, 1'b1});
    step(1'b0, 1'b0, 1'b0, 1'b1, 4'd10);
    step(1'b1, 1'b0, 1'b0, 1'b1, 4'd0);
    check("R12 10->11 binary", {qb, tcb_n}, {4'd11, 1'b1});

    // R1: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    load_n = 1'b1; en_par_n = 1'b1; en_trk_n = 1'b1;
    #1;
    check("R1 async reset", {q, tc_n}, {4'd0, 1'b1});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule